// File: doc/BRIEF.md
# SPI FIFO Level and Error Interrupt Unit

This block sits between a software-visible register port and the serial engine of an SPI controller. It holds a transmit queue that software fills and the serial engine drains, and a receive queue that the serial engine fills and software drains. Both queues live inside the block. Around them it keeps two programmable level thresholds, live occupancy counters, three sticky error flags, a six-bit interrupt enable mask, and a single interrupt output.

Software sets the thresholds and mask, turns the block on, and then moves frames through a single data register. The interrupt output tells software two things: the transmit queue has drained low enough to refill, or the receive queue holds enough frames to fetch. It also reports when a queue was misused. A threshold register keeps a written value only when that value is below the queue depth. Software can therefore find the depth by writing rising values and reading them back.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: Raw status bit 0 (transmit low) is 1 exactly when the transmit level is less than or equal to the transmit threshold (register 1).
- R2: Raw status bit 4 (receive high) is 1 exactly when the receive level is greater than the receive threshold (register 2). A threshold of N-1 therefore fires at N frames.
- R3: If the serial side pushes into a full receive queue while software does not read the data register in that cycle, sticky bit 3 is set, the frame is discarded and the level stays at the depth.
- R4: Reading the data register (address 9) while the receive queue is empty sets sticky bit 2 and returns 0.
- R5: Writing the data register while the transmit queue is full, with no serial pop in that cycle, sets sticky bit 1 and discards the frame.
- R6: Raw status (address 6) shows every source whatever the mask holds. Masked status (address 7) is raw AND mask (address 5, 6 bits). The interrupt output is the OR of the masked bits. Raw bit 5 always reads 0.
- R7: The transmit level (address 3) and receive level (address 4) always show the current occupancy. Frames leave each queue in the order they entered. The serial side sees the head transmit frame on tx_frame and a nonempty flag on tx_ready.
- R8: A write to a threshold register takes effect only when the value is below the depth. Otherwise the old value stays. Both thresholds reset to 0.
- R9: Control bit 0 (address 0) is the enable and resets to 0. From the cycle after the enable reads 0, both queues are empty and all sticky flags are 0. While the block is disabled, data writes, data reads and serial pushes have no effect.
- R10: Reading address 8 returns the sticky flags at bits 1 to 3 and clears them. An error event in the same cycle sets its flag regardless.
- R11: A push and a pop on the same nonempty queue in one cycle leave its level unchanged and raise no error, even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe; triggers read side effects |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tx_pop | input | 1 | Serial engine takes the head transmit frame |
| tx_ready | output | 1 | Transmit queue is not empty |
| tx_frame | output | DATA_W | Head transmit frame |
| rx_push | input | 1 | Serial engine delivers a received frame |
| rx_frame | input | DATA_W | Received frame |
| irq | output | 1 | OR of masked status bits |

## Verification
A corrupted level counter shows up at once in the level registers and in the threshold status bits. A corrupted pointer shows up as a wrong frame on tx_frame or in the data register on the next pop. A sticky flag that is lost or set spuriously changes the raw status and the interrupt output in the cycle after the event. For that reason, a behavioural queue model is compared against irq, tx_ready and tx_frame on every clock, and against every register read. The directed steps target the full and empty edges, threshold readback above the depth, an event that coincides with a clear, and the flush on disable.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    typedef enum logic [3:0] {
        REG_CTRL   = 4'd0,
        REG_TX_THR = 4'd1,
        REG_RX_THR = 4'd2,
        REG_TX_LVL = 4'd3,
        REG_RX_LVL = 4'd4,
        REG_MASK   = 4'd5,
        REG_RAW    = 4'd6,
        REG_MSKD   = 4'd7,
        REG_ICLR   = 4'd8,
        REG_DATA   = 4'd9
    } reg_addr_e;

    localparam int IRQ_W = 6;

    typedef struct packed {
        logic rx_ovf;
        logic rx_udf;
        logic tx_ovf;
    } err_t;

    function automatic logic [IRQ_W-1:0] pack_status(input logic tx_low, input err_t e,
                                                     input logic rx_high);
        return {1'b0, rx_high, e.rx_ovf, e.rx_udf, e.tx_ovf, tx_low};
    endfunction

endpackage

// File: rtl/spi_fifo_store.sv
module spi_fifo_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [WIDTH-1:0]           push_data,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty,
    output logic                       overflow,
    output logic                       underflow
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [IW-1:0]    rd_ptr, wr_ptr;
    logic [LW-1:0]    count;
    logic             full, pop_ok, push_ok;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (count == '0);
    assign full      = (count == LW'(DEPTH));
    assign pop_ok    = pop && !empty;
    assign push_ok   = push && (!full || pop_ok);
    assign overflow  = push && !push_ok;
    assign underflow = pop && empty;
    assign level     = count;
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wr_ptr] <= push_data;
    end

    // R7: occupancy never exceeds the depth
    assert_level_bound_R7: assert property (@(posedge clk) disable iff (rst)
        count <= LW'(DEPTH));

    // R3 / R5: a dropped push leaves the queue full
    assert_drop_keeps_full_R3: assert property (@(posedge clk) disable iff (rst)
        (overflow && !flush) |=> (count == LW'(DEPTH)));

    // R11: push and pop together on a nonempty queue keep the level
    assert_pair_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty && !flush) |=> $stable(count));

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_fifo_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tx_ovf_evt,
    input  logic             rx_udf_evt,
    input  logic             rx_ovf_evt,
    input  logic [LW-1:0]    tx_lvl,
    input  logic [LW-1:0]    tx_thr,
    input  logic [LW-1:0]    rx_lvl,
    input  logic [LW-1:0]    rx_thr,
    input  logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked,
    output err_t             err,
    output logic             irq
);
    err_t err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= '0;
        end else begin
            err_q.tx_ovf <= (err_q.tx_ovf && !clear) || tx_ovf_evt;
            err_q.rx_udf <= (err_q.rx_udf && !clear) || rx_udf_evt;
            err_q.rx_ovf <= (err_q.rx_ovf && !clear) || rx_ovf_evt;
        end
    end

    assign err    = err_q;
    assign raw    = pack_status(tx_lvl <= tx_thr, err_q, rx_lvl > rx_thr);
    assign masked = raw & mask;
    assign irq    = |masked;

    assert_txovf_sets_R5: assert property (@(posedge clk) disable iff (rst)
        tx_ovf_evt |=> err_q.tx_ovf);

    assert_rxudf_sets_R4: assert property (@(posedge clk) disable iff (rst)
        rx_udf_evt |=> err_q.rx_udf);

    assert_rxovf_sets_R3: assert property (@(posedge clk) disable iff (rst)
        rx_ovf_evt |=> err_q.rx_ovf);

    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (rst)
        (clear && !tx_ovf_evt && !rx_udf_evt && !rx_ovf_evt) |=> (err_q == '0));

    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (err_q.rx_ovf && !clear) |=> err_q.rx_ovf);

endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tx_pop,
    output logic              tx_ready,
    output logic [DATA_W-1:0] tx_frame,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_frame,
    output logic              irq
);
    localparam int LW = $clog2(DEPTH + 1);

    logic             enable_q;
    logic [LW-1:0]    tx_thr_q, rx_thr_q;
    logic [IRQ_W-1:0] mask_q;

    logic              wr_data, rd_data, rd_iclr, flush;
    logic              thr_ok;
    logic [DATA_W-1:0] rx_head;
    logic [LW-1:0]     tx_lvl, rx_lvl;
    logic              tx_empty, rx_empty;
    logic              tx_over, tx_under, rx_over, rx_under;
    logic [IRQ_W-1:0]  raw, masked;
    err_t              err;

    assign wr_data = reg_wr_en && (reg_addr == REG_DATA) && enable_q;
    assign rd_data = reg_rd_en && (reg_addr == REG_DATA) && enable_q;
    assign rd_iclr = reg_rd_en && (reg_addr == REG_ICLR);
    assign flush   = !enable_q;
    assign thr_ok  = (reg_wdata < 32'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= 1'b0;
            tx_thr_q <= '0;
            rx_thr_q <= '0;
            mask_q   <= '0;
        end else if (reg_wr_en) begin
            case (reg_addr)
                REG_CTRL:   enable_q <= reg_wdata[0];
                REG_TX_THR: if (thr_ok) tx_thr_q <= reg_wdata[LW-1:0];
                REG_RX_THR: if (thr_ok) rx_thr_q <= reg_wdata[LW-1:0];
                REG_MASK:   mask_q   <= reg_wdata[IRQ_W-1:0];
                default:    ;
            endcase
        end
    end

    spi_fifo_store #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_tx_q (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (wr_data),
        .push_data (reg_wdata[DATA_W-1:0]),
        .pop       (tx_pop && enable_q),
        .head      (tx_frame),
        .level     (tx_lvl),
        .empty     (tx_empty),
        .overflow  (tx_over),
        .underflow (tx_under)
    );

    spi_fifo_store #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rx_q (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (rx_push && enable_q),
        .push_data (rx_frame),
        .pop       (rd_data),
        .head      (rx_head),
        .level     (rx_lvl),
        .empty     (rx_empty),
        .overflow  (rx_over),
        .underflow (rx_under)
    );

    spi_irq_status #(.LW(LW)) u_status (
        .clk        (clk),
        .rst        (rst),
        .clear      (rd_iclr || flush),
        .tx_ovf_evt (tx_over),
        .rx_udf_evt (rx_under),
        .rx_ovf_evt (rx_over),
        .tx_lvl     (tx_lvl),
        .tx_thr     (tx_thr_q),
        .rx_lvl     (rx_lvl),
        .rx_thr     (rx_thr_q),
        .mask       (mask_q),
        .raw        (raw),
        .masked     (masked),
        .err        (err),
        .irq        (irq)
    );

    assign tx_ready = !tx_empty;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL:   reg_rdata = {31'd0, enable_q};
            REG_TX_THR: reg_rdata = 32'(tx_thr_q);
            REG_RX_THR: reg_rdata = 32'(rx_thr_q);
            REG_TX_LVL: reg_rdata = 32'(tx_lvl);
            REG_RX_LVL: reg_rdata = 32'(rx_lvl);
            REG_MASK:   reg_rdata = 32'(mask_q);
            REG_RAW:    reg_rdata = 32'(raw);
            REG_MSKD:   reg_rdata = 32'(masked);
            REG_ICLR:   reg_rdata = 32'({err.rx_ovf, err.rx_udf, err.tx_ovf, 1'b0});
            REG_DATA:   reg_rdata = rx_empty ? '0 : 32'(rx_head);
            default:    reg_rdata = '0;
        endcase
    end

    // R8: thresholds always stay below the depth
    assert_thr_below_depth_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_thr_q < LW'(DEPTH)) && (rx_thr_q < LW'(DEPTH)));

    assert_thr_reject_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == REG_TX_THR && !thr_ok) |=> $stable(tx_thr_q));

    // R9: disabled block holds both queues empty
    assert_disabled_empty_R9: assert property (@(posedge clk) disable iff (rst)
        (!enable_q && !(reg_wr_en && reg_addr == REG_CTRL)) |=> (tx_empty && rx_empty));

    // R7: serial engine only pops a ready transmit queue
    assert_tx_pop_guard_R7: assert property (@(posedge clk) disable iff (rst)
        !tx_under);

endmodule

// File: tb/test_spi_fifo_irq_ctrl.sv
module test_spi_fifo_irq_ctrl;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_pop = 1'b0, tx_ready;
    logic [15:0] tx_frame;
    logic        rx_push = 1'b0;
    logic [15:0] rx_frame = '0;
    logic        irq;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    spi_fifo_irq_ctrl #(.DEPTH(D), .DATA_W(16)) i_spi_fifo_irq_ctrl (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_ready(tx_ready), .tx_frame(tx_frame),
        .rx_push(rx_push), .rx_frame(rx_frame), .irq(irq));

    // behavioural reference model
    logic [15:0] q_tx[$];
    logic [15:0] q_rx[$];
    bit          m_en;
    int          m_txthr, m_rxthr;
    logic [5:0]  m_mask;
    bit          m_txo, m_rxu, m_rxo;

    function automatic logic [31:0] m_raw();
        return {26'd0, 1'b0, q_rx.size() > m_rxthr, m_rxo, m_rxu, m_txo,
                q_tx.size() <= m_txthr};
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return {31'd0, m_en};
            4'd1: return m_txthr;
            4'd2: return m_rxthr;
            4'd3: return q_tx.size();
            4'd4: return q_rx.size();
            4'd5: return {26'd0, m_mask};
            4'd6: return m_raw();
            4'd7: return m_raw() & {26'd0, m_mask};
            4'd8: return {28'd0, m_rxo, m_rxu, m_txo, 1'b0};
            4'd9: return (q_rx.size() > 0) ? {16'd0, q_rx[0]} : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit en0, icr, tx_ok, rx_ok, txo_e, rxu_e, rxo_e;
        if (rst) begin
            q_tx.delete(); q_rx.delete();
            m_en = 0; m_txthr = 0; m_rxthr = 0; m_mask = '0;
            m_txo = 0; m_rxu = 0; m_rxo = 0;
        end else begin
            en0 = m_en;
            icr = reg_rd_en && reg_addr == 4'd8;
            txo_e = 0; rxu_e = 0; rxo_e = 0;
            if (!en0) begin
                q_tx.delete(); q_rx.delete();
                m_txo = 0; m_rxu = 0; m_rxo = 0;
            end else begin
                tx_ok = tx_pop && q_tx.size() > 0;
                rx_ok = reg_rd_en && reg_addr == 4'd9 && q_rx.size() > 0;
                rxu_e = reg_rd_en && reg_addr == 4'd9 && q_rx.size() == 0;
                if (reg_wr_en && reg_addr == 4'd9) begin
                    if (q_tx.size() < D || tx_ok) q_tx.push_back(reg_wdata[15:0]);
                    else txo_e = 1;
                end
                if (tx_ok) void'(q_tx.pop_front());
                if (rx_push) begin
                    if (q_rx.size() < D || rx_ok) q_rx.push_back(rx_frame);
                    else rxo_e = 1;
                end
                if (rx_ok) void'(q_rx.pop_front());
                m_txo = (m_txo && !icr) || txo_e;
                m_rxu = (m_rxu && !icr) || rxu_e;
                m_rxo = (m_rxo && !icr) || rxo_e;
            end
            if (reg_wr_en) begin
                case (reg_addr)
                    4'd0: m_en = reg_wdata[0];
                    4'd1: if (reg_wdata < D) m_txthr = reg_wdata;
                    4'd2: if (reg_wdata < D) m_rxthr = reg_wdata;
                    4'd5: m_mask = reg_wdata[5:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FIFO-UNIT FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison of state-driven outputs
    always @(negedge clk) begin
        if (!rst) begin
            check("R6 irq", {31'd0, irq}, {31'd0, |(m_raw() & {26'd0, m_mask})});
            check("R7 tx_ready", {31'd0, tx_ready}, {31'd0, q_tx.size() > 0});
            if (q_tx.size() > 0) check("R7 tx_frame", {16'd0, tx_frame}, {16'd0, q_tx[0]});
        end
    end

    task automatic cyc(input logic w, input logic r, input logic [3:0] a, input logic [31:0] d,
                       input logic tp, input logic rp, input logic [15:0] rf, input string tag);
        reg_wr_en = w; reg_rd_en = r; reg_addr = a; reg_wdata = d;
        tx_pop = tp; rx_push = rp; rx_frame = rf;
        #1;
        if (r) check(tag, reg_rdata, m_read(a));
        @(negedge clk);
        reg_wr_en = 0; reg_rd_en = 0; tx_pop = 0; rx_push = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1, 0, a, d, 0, 0, 0, "");
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc(0, 1, a, 0, 0, 0, 0, tag);
    endtask

    task automatic peek(input logic [3:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state
        peek(4'd0, 32'h0, "R9 ctrl reset");
        peek(4'd3, 32'h0, "R7 txlvl reset");
        peek(4'd6, 32'h1, "R1 raw reset");
        wr(4'd0, 1);
        // R8 threshold readback
        wr(4'd1, D);      peek(4'd1, 0, "R8 reject depth");
        wr(4'd1, D - 1);  peek(4'd1, D - 1, "R8 accept max");
        wr(4'd1, 40);     peek(4'd1, D - 1, "R8 keep old");
        wr(4'd1, 4);
        // R1 and R7 transmit side
        for (int i = 0; i < 6; i++) wr(4'd9, 32'hA0 + i);
        peek(4'd3, 6, "R7 txlvl 6");
        peek(4'd6, 32'h0, "R1 above thr");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0, 0, "");
        peek(4'd3, 3, "R7 txlvl 3");
        peek(4'd6, 32'h1, "R1 at or below thr");
        rd(4'd3, "R7 read txlvl");
        // R5 overflow
        for (int i = 0; i < 13; i++) wr(4'd9, 32'hB0 + i);
        peek(4'd3, D, "R5 full");
        wr(4'd9, 32'hDEAD);
        peek(4'd3, D, "R5 level kept");
        peek(4'd6, 32'h2, "R5 sticky");
        rd(4'd8, "R10 iclr read");
        peek(4'd6, 32'h0, "R10 cleared");
        // R11 push+pop on full transmit queue
        cyc(1, 0, 4'd9, 32'hC5, 1, 0, 0, "");
        peek(4'd3, D, "R11 tx level");
        peek(4'd6, 32'h0, "R11 no error");
        for (int i = 0; i < D; i++) cyc(0, 0, 0, 0, 1, 0, 0, "");
        peek(4'd3, 0, "R7 tx drained");
        // R2 receive threshold
        wr(4'd2, 2);
        for (int i = 0; i < 2; i++) cyc(0, 0, 0, 0, 0, 1, 16'h100 + i[15:0], "");
        peek(4'd6, 32'h1, "R2 not above");
        cyc(0, 0, 0, 0, 0, 1, 16'h102, "");
        peek(4'd6, 32'h11, "R2 above thr");
        // R3 overflow
        for (int i = 3; i < D; i++) cyc(0, 0, 0, 0, 0, 1, 16'h100 + i[15:0], "");
        cyc(0, 0, 0, 0, 0, 1, 16'hBEEF, "");
        peek(4'd4, D, "R3 level kept");
        peek(4'd6, 32'h19, "R3 sticky");
        rd(4'd8, "R10 iclr rx");
        // R11 on full receive queue
        cyc(0, 1, 4'd9, 0, 0, 1, 16'h1F0, "R11 data read");
        peek(4'd4, D, "R11 rx level");
        peek(4'd6, 32'h11, "R11 no rx error");
        // R10 event in same cycle as clear
        cyc(0, 1, 4'd8, 0, 0, 1, 16'hBAD0, "R10 clear read");
        peek(4'd6, 32'h19, "R10 event wins");
        rd(4'd8, "R10 clear again");
        // drain, then R4
        for (int i = 0; i < D; i++) rd(4'd9, "R3 R7 data order");
        peek(4'd9, 0, "R4 empty data");
        rd(4'd9, "R4 empty read");
        peek(4'd6, 32'h5, "R4 sticky");
        // R6 masking
        wr(4'd5, 32'h4);
        peek(4'd7, 32'h4, "R6 masked");
        check("R6 irq high", {31'd0, irq}, 32'h1);
        wr(4'd5, 32'h10);
        check("R6 irq low", {31'd0, irq}, 32'h0);
        peek(4'd6, 32'h5, "R6 raw unmasked");
        wr(4'd5, 32'h3F);
        // R9 disable
        cyc(0, 0, 0, 0, 0, 1, 16'h77, "");
        wr(4'd9, 32'h55);
        wr(4'd0, 0);
        @(negedge clk);
        peek(4'd3, 0, "R9 tx flushed");
        peek(4'd4, 0, "R9 rx flushed");
        peek(4'd8, 0, "R9 errors cleared");
        wr(4'd9, 32'h66);
        cyc(0, 0, 0, 0, 0, 1, 16'h88, "");
        rd(4'd9, "R9 read ignored");
        peek(4'd3, 0, "R9 write ignored");
        peek(4'd4, 0, "R9 push ignored");
        peek(4'd6, 32'h1, "R9 raw idle");
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FIFO-UNIT FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule